// File: doc/BRIEF.md
# Data Memory Lane Alignment Unit

This unit sits between a processor core and a 32-bit data memory that is addressed by whole words. For a store, it places the source operand on the byte lanes the access touches and produces a byte-enable mask, so the memory writes only those bytes. For a load, it takes the word read from memory, moves the addressed byte or halfword down to bit 0, and then fills the upper bits with either the sign bit or zeros.

The core passes in the low bits of the effective address, the access size, a flag that selects zero-extension, a store/load flag, the store operand and the memory read word, along with a valid strobe. The unit registers every result and presents it one clock later. It also reports accesses that cross their natural alignment. A misaligned access produces no byte enables and no load data.

Top module: `mla_lane_align`

## Requirements
- R1: All outputs are registered, and `out_valid` is `in_valid` delayed by one clock. While `rst_n` is low, `out_valid`, `byte_en`, `misaligned`, `wr_data` and `ld_data` are all zero.
- R2: A word load (`size` = 2'b10) at lane offset 0 returns `rd_word` unchanged on `ld_data`.
- R3: A halfword load (`size` = 2'b01) at offset 0 or 2 returns bits [8*off+15:8*off] of `rd_word`. The upper 16 bits are copies of bit 15 of the result when `is_unsigned` = 0, and zero when `is_unsigned` = 1.
- R4: A byte load (`size` = 2'b00) at offset k (0 to 3) returns bits [8k+7:8k] of `rd_word`. The upper 24 bits are copies of bit 7 of the result when `is_unsigned` = 0, and zero when `is_unsigned` = 1.
- R5: For a byte access, `wr_data` holds `wr_src[7:0]` copied into all four lanes. For a byte store, `byte_en` = 4'b0001 shifted left by the offset.
- R6: For a halfword access, `wr_data` = {`wr_src[15:0]`, `wr_src[15:0]`}. For an aligned halfword store, `byte_en` is 4'b0011 at offset 0 and 4'b1100 at offset 2.
- R7: For a word access, `wr_data` = `wr_src`. For an aligned word store, `byte_en` = 4'b1111.
- R8: When a halfword access has offset bit 0 set, or a word access has a nonzero offset, `misaligned` is 1, `byte_en` is 0 and `ld_data` is 0. Byte accesses never set `misaligned`.
- R9: A load (`is_store` = 0) always gives `byte_en` = 0. A store always gives `ld_data` = 0.
- R10: The size code 2'b11 behaves exactly like a word access in every output.
- R11: After a cycle with `in_valid` low, `byte_en` is 0. `wr_data`, `ld_data` and `misaligned` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| is_store | input | 1 | 1 = store, 0 = load |
| size | input | 2 | 00 byte, 01 halfword, 10 word, 11 word |
| is_unsigned | input | 1 | Zero-extend load data when 1 |
| addr_lo | input | 2 | Byte offset of the effective address within its word |
| wr_src | input | 32 | Store source operand |
| rd_word | input | 32 | Word read from data memory |
| out_valid | output | 1 | Registered results are valid |
| wr_data | output | 32 | Lane-replicated store data |
| byte_en | output | 4 | Per-lane write enable |
| ld_data | output | 32 | Aligned and extended load result |
| misaligned | output | 1 | Access crosses its natural alignment |

## Verification
The assertions assume that `in_valid`, `is_store` and `size` hold known values in every cycle after reset. They also assume `rd_word` is presented in the same cycle as its load request. The bench meets these assumptions by driving every input on the falling edge and holding `in_valid` low throughout reset. It sweeps every combination of size code, signedness, direction and lane offset. Operand patterns include values whose byte and halfword top bits are set, so the sign-extension paths are exercised. Idle cycles are placed between bursts to test that results hold.

// File: rtl/mla_pkg.sv
package mla_pkg;
  typedef enum logic [1:0] {
    ACC_BYTE = 2'b00,
    ACC_HALF = 2'b01,
    ACC_WORD = 2'b10,
    ACC_WIDE = 2'b11
  } acc_size_e;

  function automatic logic is_full_word(input acc_size_e s);
    return (s == ACC_WORD) || (s == ACC_WIDE);
  endfunction
endpackage

// File: rtl/mla_align_detect.sv
module mla_align_detect
  import mla_pkg::*;
#(
  parameter int LANE_W = 2
) (
  input  acc_size_e         size,
  input  logic [LANE_W-1:0] lane,
  output logic              misaligned
);
  always_comb begin
    unique case (size)
      ACC_BYTE: misaligned = 1'b0;
      ACC_HALF: misaligned = lane[0];
      default:  misaligned = |lane;
    endcase
  end
endmodule

// File: rtl/mla_store_steer.sv
module mla_store_steer
  import mla_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int LANE_W = $clog2(LANES)
) (
  input  acc_size_e         size,
  input  logic [LANE_W-1:0] lane,
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  be
);
  localparam int HALF_W = LANE_W - 1;

  logic [HALF_W-1:0] half_sel;
  assign half_sel = lane[LANE_W-1:1];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int HIDX = g / 2;
    localparam logic [LANE_W-1:0] LIDX = LANE_W'(g);
    localparam logic [HALF_W-1:0] HSEL = HALF_W'(HIDX);
    always_comb begin
      unique case (size)
        ACC_BYTE: begin
          wdata[8*g +: 8] = src[7:0];
          be[g]           = (lane == LIDX);
        end
        ACC_HALF: begin
          wdata[8*g +: 8] = src[8*(g%2) +: 8];
          be[g]           = (half_sel == HSEL);
        end
        default: begin
          wdata[8*g +: 8] = src[8*g +: 8];
          be[g]           = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/mla_load_extract.sv
module mla_load_extract
  import mla_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = $clog2(DATA_W / 8)
) (
  input  acc_size_e         size,
  input  logic [LANE_W-1:0] lane,
  input  logic              zext,
  input  logic [DATA_W-1:0] rd,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] shifted;
  logic              byte_fill;
  logic              half_fill;

  assign shifted   = rd >> {lane, 3'b000};
  assign byte_fill = ~zext & shifted[7];
  assign half_fill = ~zext & shifted[15];

  always_comb begin
    unique case (size)
      ACC_BYTE: result = {{(DATA_W-8){byte_fill}}, shifted[7:0]};
      ACC_HALF: result = {{(DATA_W-16){half_fill}}, shifted[15:0]};
      default:  result = rd;
    endcase
  end
endmodule

// File: rtl/mla_lane_align.sv
module mla_lane_align
  import mla_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              is_store,
  input  logic [1:0]        size,
  input  logic              is_unsigned,
  input  logic [LANE_W-1:0] addr_lo,
  input  logic [DATA_W-1:0] wr_src,
  input  logic [DATA_W-1:0] rd_word,
  output logic              out_valid,
  output logic [DATA_W-1:0] wr_data,
  output logic [LANES-1:0]  byte_en,
  output logic [DATA_W-1:0] ld_data,
  output logic              misaligned
);
  acc_size_e         acc;
  logic              mis_c;
  logic [DATA_W-1:0] steer_c;
  logic [LANES-1:0]  be_c;
  logic [DATA_W-1:0] ld_c;

  logic              valid_nxt;
  logic [DATA_W-1:0] wdata_nxt;
  logic [LANES-1:0]  be_nxt;
  logic [DATA_W-1:0] ld_nxt;
  logic              mis_nxt;

  assign acc = acc_size_e'(size);

  mla_align_detect #(.LANE_W(LANE_W)) u_detect (
    .size       (acc),
    .lane       (addr_lo),
    .misaligned (mis_c)
  );

  mla_store_steer #(.DATA_W(DATA_W), .LANES(LANES), .LANE_W(LANE_W)) u_steer (
    .size  (acc),
    .lane  (addr_lo),
    .src   (wr_src),
    .wdata (steer_c),
    .be    (be_c)
  );

  mla_load_extract #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_extract (
    .size   (acc),
    .lane   (addr_lo),
    .zext   (is_unsigned),
    .rd     (rd_word),
    .result (ld_c)
  );

  // next-state
  always_comb begin
    valid_nxt = in_valid;
    wdata_nxt = wr_data;
    ld_nxt    = ld_data;
    mis_nxt   = misaligned;
    be_nxt    = '0;
    if (in_valid) begin
      wdata_nxt = steer_c;
      mis_nxt   = mis_c;
      ld_nxt    = (is_store || mis_c) ? '0 : ld_c;
      be_nxt    = (is_store && !mis_c) ? be_c : '0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      wr_data    <= '0;
      byte_en    <= '0;
      ld_data    <= '0;
      misaligned <= 1'b0;
    end else begin
      out_valid  <= valid_nxt;
      wr_data    <= wdata_nxt;
      byte_en    <= be_nxt;
      ld_data    <= ld_nxt;
      misaligned <= mis_nxt;
    end
  end
endmodule

// File: rtl/mla_lane_align_checker.sv
module mla_lane_align_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        is_store,
  input logic [1:0]  size,
  input logic [1:0]  addr_lo,
  input logic [31:0] rd_word,
  input logic        out_valid,
  input logic [3:0]  byte_en,
  input logic [31:0] ld_data,
  input logic        misaligned
);
  p_valid_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  p_word_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is_store && size[1] && addr_lo == 2'b00) |=> (ld_data == $past(rd_word)));

  p_store_be_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_store && size == 2'b00) |=> ($countones(byte_en) == 1));

  p_half_be_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_store && size == 2'b01 && !addr_lo[0]) |=> ($countones(byte_en) == 2));

  p_no_be_misaligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    misaligned && out_valid |-> byte_en == 4'b0000);

  p_byte_never_mis_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size == 2'b00) |=> !misaligned);

  p_load_no_be_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is_store) |=> (byte_en == 4'b0000));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (byte_en == 4'b0000 && $stable(ld_data) && $stable(misaligned)));
endmodule

bind mla_lane_align mla_lane_align_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .is_store   (is_store),
  .size       (size),
  .addr_lo    (addr_lo),
  .rd_word    (rd_word),
  .out_valid  (out_valid),
  .byte_en    (byte_en),
  .ld_data    (ld_data),
  .misaligned (misaligned)
);

// File: tb/mla_lane_align_bench.sv
module mla_lane_align_bench;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        is_store;
  logic [1:0]  size;
  logic        is_unsigned;
  logic [1:0]  addr_lo;
  logic [31:0] wr_src;
  logic [31:0] rd_word;
  logic        out_valid;
  logic [31:0] wr_data;
  logic [3:0]  byte_en;
  logic [31:0] ld_data;
  logic        misaligned;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  mla_lane_align u_mla_lane_align (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .is_store(is_store),
    .size(size), .is_unsigned(is_unsigned), .addr_lo(addr_lo),
    .wr_src(wr_src), .rd_word(rd_word), .out_valid(out_valid),
    .wr_data(wr_data), .byte_en(byte_en), .ld_data(ld_data),
    .misaligned(misaligned)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural reference: byte counts per size code (R10: 3 acts as word)
  function automatic int nbytes(input logic [1:0] s);
    if (s == 2'd0) return 1;
    if (s == 2'd1) return 2;
    return 4;
  endfunction

  function automatic bit ref_mis(input logic [1:0] s, input logic [1:0] off);
    return (int'(off) % nbytes(s)) != 0;
  endfunction

  function automatic logic [31:0] ref_wdata(input logic [1:0] s, input logic [31:0] src);
    logic [31:0] r;
    int n = nbytes(s);
    for (int b = 0; b < 4; b++) r[8*b +: 8] = src[8*(b % n) +: 8];
    return r;
  endfunction

  function automatic logic [3:0] ref_be(input logic st, input logic [1:0] s,
                                        input logic [1:0] off);
    logic [3:0] r = 4'b0000;
    int n = nbytes(s);
    if (!st || ref_mis(s, off)) return r;
    for (int b = 0; b < 4; b++) if (b >= int'(off) && b < int'(off) + n) r[b] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] ref_ld(input logic st, input logic [1:0] s,
                                         input logic u, input logic [1:0] off,
                                         input logic [31:0] rd);
    logic [31:0] r;
    int n = nbytes(s);
    bit fill;
    if (st || ref_mis(s, off)) return 32'h0;
    fill = !u && rd[8*(int'(off) + n) - 1];
    for (int i = 0; i < 32; i++)
      r[i] = (i < 8*n) ? rd[8*int'(off) + i] : fill;
    return r;
  endfunction

  function automatic string ld_req(input logic [1:0] s);
    if (s == 2'd0) return "R4";
    if (s == 2'd1) return "R3";
    if (s == 2'd2) return "R2";
    return "R10";
  endfunction

  function automatic string st_req(input logic [1:0] s);
    if (s == 2'd0) return "R5";
    if (s == 2'd1) return "R6";
    if (s == 2'd2) return "R7";
    return "R10";
  endfunction

  task automatic txn(input logic st, input logic [1:0] s, input logic u,
                     input logic [1:0] off, input logic [31:0] src, input logic [31:0] rd);
    in_valid = 1'b1; is_store = st; size = s; is_unsigned = u;
    addr_lo = off; wr_src = src; rd_word = rd;
    @(negedge clk);
    check("R1", "out_valid", {31'b0, out_valid}, 32'd1);
    check("R8", "misaligned", {31'b0, misaligned}, {31'b0, ref_mis(s, off)});
    check(st_req(s), "wr_data", wr_data, ref_wdata(s, src));
    check(st ? st_req(s) : "R9", "byte_en", {28'b0, byte_en}, {28'b0, ref_be(st, s, off)});
    check(st ? "R9" : ld_req(s), "ld_data", ld_data, ref_ld(st, s, u, off, rd));
  endtask

  task automatic idle();
    logic [31:0] pw, pl;
    logic pm;
    pw = wr_data; pl = ld_data; pm = misaligned;
    in_valid = 1'b0; wr_src = ~wr_src; rd_word = ~rd_word;
    @(negedge clk);
    check("R11", "out_valid", {31'b0, out_valid}, 32'd0);
    check("R11", "byte_en", {28'b0, byte_en}, 32'd0);
    check("R11", "wr_data", wr_data, pw);
    check("R11", "ld_data", ld_data, pl);
    check("R11", "misaligned", {31'b0, misaligned}, {31'b0, pm});
  endtask

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'h8F7E_80A5;
    pats[1] = 32'h1234_5678;
    pats[2] = 32'hFFFF_0080;
    pats[3] = 32'h7F80_807F;
    rst_n = 1'b0; in_valid = 1'b0; is_store = 1'b0; size = 2'b00;
    is_unsigned = 1'b0; addr_lo = 2'b00; wr_src = '0; rd_word = '0;
    repeat (3) @(negedge clk);
    check("R1", "reset out_valid", {31'b0, out_valid}, 32'd0);
    check("R1", "reset byte_en", {28'b0, byte_en}, 32'd0);
    check("R1", "reset ld_data", ld_data, 32'd0);
    check("R1", "reset wr_data", wr_data, 32'd0);
    check("R1", "reset misaligned", {31'b0, misaligned}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int p = 0; p < 4; p++) begin
      for (int st = 0; st < 2; st++)
        for (int s = 0; s < 4; s++)
          for (int u = 0; u < 2; u++)
            for (int o = 0; o < 4; o++)
              txn(st[0], s[1:0], u[0], o[1:0], pats[p] ^ {p[7:0], 24'h0},
                  pats[(p + 1) % 4] ^ {8'h0, o[7:0], 16'h0});
      idle();
      idle();
    end
    done = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule